// File: doc/BRIEF.md
# Multiprocessor-Capable 9-bit UART

This block is an asynchronous serial port for a small controller. Software configures and monitors it through one 8-bit control/status register and moves characters through one data register, both on a single-cycle register bus. A frame is a low start bit, then the data bits LSB first, then an optional ninth bit, then one high stop bit. Bit timing comes from an external tick that runs at sixteen times the bit rate.

The ninth bit comes from a software-controlled control bit on transmit. On receive it is latched into a status bit, so it can carry parity or an address/data marker. When the multiprocessor filter is on, the receiver drops frames whose marker is clear. Nodes on a shared line can then ignore data traffic until they are addressed. The transmit-done and receive-done flags are set by hardware and stay set until software writes them to 0.

Control register bits: bit 7 and bit 6 form the mode code. Code 01 selects 8 data bits. Codes 10 and 11 select 9 data bits. Code 00 is handled like 01. The remaining bits are:
- bit 5: multiprocessor filter
- bit 4: receive enable
- bit 3: ninth bit to send
- bit 2: ninth bit received
- bit 1: transmit done
- bit 0: receive done

Address 0 selects the control register and address 1 selects the data register.

Top module: `uart9_port`

## Requirements
- R1: After reset, the control register reads 0x00, the data register reads 0x00, and `txd` is 1.
- R2: With mode code 01, a write to address 1 while the transmitter is idle sends a start bit (0), then the 8 data bits LSB first, then a stop bit (1). Each bit lasts 16 ticks.
- R3: With mode codes 10 or 11, control bit 3 is sent as a ninth bit between the eighth data bit and the stop bit.
- R4: Control bit 1 becomes 1 when the stop bit of a transmitted frame ends. It stays 1 until software writes it to 0.
- R5: A write to address 1 while a frame is being sent is ignored and produces no extra frame.
- R6: With mode code 01 and the filter off, a received frame loads its data into address 1 and sets control bit 0. It also copies the received stop bit into control bit 2.
- R7: With mode codes 10 or 11, a received frame copies its ninth bit into control bit 2 and loads its data into address 1.
- R8: While control bit 4 is 0, no frame is received: bit 0 stays 0 and address 1 is unchanged.
- R9: With the filter (bit 5) on and mode codes 10 or 11, a frame whose ninth bit is 0 leaves bit 0 and address 1 unchanged. A frame whose ninth bit is 1 is accepted.
- R10: With the filter on and mode code 01, a frame whose stop bit is 0 is discarded. A frame whose stop bit is 1 is accepted.
- R11: A frame that completes while bit 0 is still 1 is discarded, and address 1 keeps its old value.
- R12: A start bit that is no longer low at its middle (8 ticks after detection) is rejected, and the receiver returns to waiting for a new start.
- R13: If hardware sets bit 1 or bit 0 in the same cycle that software writes it to 0, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle pulse at sixteen times the bit rate |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 1 | 0 = control register, 1 = data register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output, idles high |

## Verification
On transmit, `txd` drops at the clock edge that takes the data write. Every bit then lasts exactly 16 ticks, and bit 1 of the control register rises at the edge that ends the stop bit: 160 ticks after the start for 8-bit frames and 176 ticks for 9-bit frames. The scoreboard monitor waits 8 ticks after it sees the line fall, then samples once every 16 ticks, so every sample falls in the middle of a bit.

On receive, the input passes through two synchronizer stages and is sampled at the ninth tick of each bit. Bit 0 rises two edges after the stop-bit sample. The receive driver therefore holds the line idle for 12 ticks after each stop bit before any register is read. Flag collisions are checked by writing a clear on every cycle across the end of a frame and watching for the flag to appear.

// File: rtl/uart9_pkg.sv
`timescale 1ns/1ps
package uart9_pkg;
    localparam int DATA_W = 8;
    localparam int OVS    = 16;

    // Control/status register, MSB first
    typedef struct packed {
        logic mode_hi;
        logic mode_lo;
        logic mp_en;
        logic rx_en;
        logic tx_bit9;
        logic rx_bit9;
        logic tx_done;
        logic rx_done;
    } ctl_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // Nine-bit frame when the upper mode bit is set
    function automatic logic frame_is_nine(input ctl_t c);
        return c.mode_hi;
    endfunction
endpackage

// File: rtl/uart9_tx.sv
`timescale 1ns/1ps
module uart9_tx
    import uart9_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int OV = OVS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          start,
    input  logic          nine,
    input  logic          bit9,
    input  logic [DW-1:0] data,
    output logic          txd,
    output logic          done
);
    localparam int FW = DW + 3;
    localparam int CW = $clog2(OV);
    localparam int BW = $clog2(FW + 1);

    logic [FW-1:0] sreg;
    logic [CW-1:0] tcnt;
    logic [BW-1:0] left;
    logic          busy;

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            sreg <= '1;
            tcnt <= '0;
            left <= '0;
            busy <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                tcnt <= '0;
                if (nine) begin
                    sreg <= {1'b1, bit9, data, 1'b0};
                    left <= BW'(FW);
                end else begin
                    sreg <= {2'b11, data, 1'b0};
                    left <= BW'(FW - 1);
                end
            end
        end else if (tick) begin
            if (tcnt == CW'(OV - 1)) begin
                tcnt <= '0;
                sreg <= {1'b1, sreg[FW-1:1]};
                left <= left - BW'(1);
                if (left == BW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else begin
                tcnt <= tcnt + CW'(1);
            end
        end
    end

    assign txd = busy ? sreg[0] : 1'b1;

    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !txd));
endmodule

// File: rtl/uart9_rx.sv
`timescale 1ns/1ps
module uart9_rx
    import uart9_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int OV = OVS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          rxd,
    input  logic          en,
    input  logic          nine,
    input  logic          mp_en,
    input  logic          full,
    output logic          accept,
    output logic [DW-1:0] data,
    output logic          bit9
);
    localparam int CW   = $clog2(OV);
    localparam int BW   = $clog2(DW + 2);
    localparam int HALF = OV / 2 - 1;

    logic [1:0]    sync;
    logic          rxs;
    rx_state_e     st;
    logic [CW-1:0] tcnt;
    logic [BW-1:0] idx;
    logic [BW-1:0] last_idx;
    logic [DW:0]   sh;
    logic [DW-1:0] fdata;
    logic          mark;
    logic          keep;

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], rxd};
    end
    assign rxs = sync[1];

    assign last_idx = nine ? BW'(DW) : BW'(DW - 1);
    assign fdata    = nine ? sh[DW-1:0] : sh[DW:1];
    assign mark     = nine ? sh[DW] : rxs;
    assign keep     = !full && (!mp_en || mark);

    always_ff @(posedge clk) begin
        accept <= 1'b0;
        if (rst) begin
            st   <= RX_IDLE;
            tcnt <= '0;
            idx  <= '0;
            sh   <= '0;
            data <= '0;
            bit9 <= 1'b0;
        end else if (!en) begin
            st   <= RX_IDLE;
            tcnt <= '0;
        end else if (tick) begin
            unique case (st)
                RX_IDLE: if (!rxs) begin
                    st   <= RX_START;
                    tcnt <= '0;
                end
                RX_START: if (tcnt == CW'(HALF)) begin
                    tcnt <= '0;
                    idx  <= '0;
                    st   <= rxs ? RX_IDLE : RX_DATA;
                end else tcnt <= tcnt + CW'(1);
                RX_DATA: if (tcnt == CW'(OV - 1)) begin
                    tcnt <= '0;
                    sh   <= {rxs, sh[DW:1]};
                    idx  <= idx + BW'(1);
                    if (idx == last_idx) st <= RX_STOP;
                end else tcnt <= tcnt + CW'(1);
                RX_STOP: if (tcnt == CW'(OV - 1)) begin
                    tcnt <= '0;
                    st   <= RX_IDLE;
                    if (keep) begin
                        accept <= 1'b1;
                        data   <= fdata;
                        bit9   <= mark;
                    end
                end else tcnt <= tcnt + CW'(1);
                default: st <= RX_IDLE;
            endcase
        end
    end

    p_mp_filter_r9: assert property (@(posedge clk) disable iff (rst)
        (accept && $past(mp_en)) |-> bit9);
    p_overrun_drop_r11: assert property (@(posedge clk) disable iff (rst)
        accept |-> !$past(full));
endmodule

// File: rtl/uart9_port.sv
`timescale 1ns/1ps
module uart9_port
    import uart9_pkg::*;
#(
    parameter int OV = OVS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rxd,
    output logic              txd
);
    ctl_t              ctl;
    ctl_t              wctl;
    logic [DATA_W-1:0] rbuf;
    logic              wr_ctl;
    logic              wr_dat;
    logic              tx_set;
    logic              rx_acc;
    logic [DATA_W-1:0] rx_data;
    logic              rx_b9;

    assign wr_ctl = bus_sel && bus_we && !bus_addr;
    assign wr_dat = bus_sel && bus_we && bus_addr;
    assign wctl   = ctl_t'(bus_wdata);

    uart9_tx #(.DW(DATA_W), .OV(OV)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick16),
        .start (wr_dat),
        .nine  (frame_is_nine(ctl)),
        .bit9  (ctl.tx_bit9),
        .data  (bus_wdata),
        .txd   (txd),
        .done  (tx_set)
    );

    uart9_rx #(.DW(DATA_W), .OV(OV)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick16),
        .rxd    (rxd),
        .en     (ctl.rx_en),
        .nine   (frame_is_nine(ctl)),
        .mp_en  (ctl.mp_en),
        .full   (ctl.rx_done),
        .accept (rx_acc),
        .data   (rx_data),
        .bit9   (rx_b9)
    );

    // Hardware updates come last so they win over a same-cycle write
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl  <= '0;
            rbuf <= '0;
        end else begin
            if (wr_ctl) ctl <= wctl;
            if (tx_set) ctl.tx_done <= 1'b1;
            if (rx_acc) begin
                ctl.rx_done <= 1'b1;
                ctl.rx_bit9 <= rx_b9;
                rbuf        <= rx_data;
            end
        end
    end

    assign bus_rdata = bus_addr ? rbuf : ctl;

    p_txdone_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl.tx_done && !wr_ctl) |=> ctl.tx_done);
    p_txset_wins_r13: assert property (@(posedge clk) disable iff (rst)
        tx_set |=> ctl.tx_done);
    p_rxset_wins_r13: assert property (@(posedge clk) disable iff (rst)
        rx_acc |=> ctl.rx_done);
    p_rx_gated_r8: assert property (@(posedge clk) disable iff (rst)
        !ctl.rx_en |=> !rx_acc);
endmodule

// File: tb/uart9_port_test.sv
`timescale 1ns/1ps
module uart9_port_test;
    typedef struct packed {
        logic [10:0] bits;
        logic [3:0]  len;
    } tx_item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       rxd = 1'b1;
    logic       txd;

    int total = 0;
    int bad = 0;
    int tx_seen = 0;
    int tx_pushed = 0;
    bit finished = 0;
    tx_item_t exp_q[$];

    uart9_port uut (
        .clk(clk), .rst(rst), .tick16(tick16),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd)
    );

    always #2 clk = ~clk;

    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            tick16 = (ph == 0);
            ph = (ph + 1) % 4;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(posedge clk);
            if (tick16) k++;
        end
        @(negedge clk);
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic push_tx(input logic [7:0] d, input bit nine, input bit b9);
        tx_item_t it;
        if (nine) begin
            it.bits = {1'b1, b9, d, 1'b0};
            it.len  = 4'd11;
        end else begin
            it.bits = {2'b11, d, 1'b0};
            it.len  = 4'd10;
        end
        exp_q.push_back(it);
        tx_pushed++;
    endtask

    task automatic send_rx(input logic [8:0] v, input bit nine, input bit stopb);
        rxd = 1'b0;
        wait_ticks(16);
        for (int i = 0; i < (nine ? 9 : 8); i++) begin
            rxd = v[i];
            wait_ticks(16);
        end
        rxd = stopb;
        wait_ticks(16);
        rxd = 1'b1;
        wait_ticks(12);
    endtask

    // Scoreboard monitor for the serial output
    initial begin
        logic [10:0] got;
        tx_item_t    e;
        int          n;
        @(negedge clk);
        while (rst) @(negedge clk);
        forever begin
            @(negedge clk);
            if (txd === 1'b0) begin
                got = '1;
                wait_ticks(8);
                got[0] = txd;
                n = (exp_q.size() > 0) ? int'(exp_q[0].len) : 11;
                for (int i = 1; i < n; i++) begin
                    wait_ticks(16);
                    got[i] = txd;
                end
                tx_seen++;
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R5 unexpected frame actual=%0h expected=none", got);
                end else begin
                    e = exp_q.pop_front();
                    if (got !== e.bits) begin
                        bad++;
                        $display("FAIL R2/R3 frame actual=%0h expected=%0h", got, e.bits);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit seen;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(1'b0, v); chk("R1 control", v, 8'h00);
        bus_read(1'b1, v); chk("R1 data", v, 8'h00);
        chk("R1 txd idle", txd, 1'b1);

        // R2/R4: 8-bit transmit, sticky done
        bus_write(1'b0, 8'h50);
        push_tx(8'hA5, 0, 0);
        bus_write(1'b1, 8'hA5);
        wait_ticks(180);
        bus_read(1'b0, v); chk("R4 done set", v[1], 1'b1);
        wait_ticks(20);
        bus_read(1'b0, v); chk("R4 done sticky", v[1], 1'b1);
        bus_write(1'b0, 8'h50);
        bus_read(1'b0, v); chk("R4 done cleared", v[1], 1'b0);

        // R5: write during transmission ignored
        push_tx(8'h3C, 0, 0);
        bus_write(1'b1, 8'h3C);
        wait_ticks(20);
        bus_write(1'b1, 8'hFF);
        wait_ticks(180);
        chk("R5 one frame", tx_seen, 2);

        // R3: ninth bit sent
        bus_write(1'b0, 8'h98);
        push_tx(8'h5A, 1, 1);
        bus_write(1'b1, 8'h5A);
        wait_ticks(195);
        bus_write(1'b0, 8'h90);
        push_tx(8'h81, 1, 0);
        bus_write(1'b1, 8'h81);
        wait_ticks(195);
        chk("R3 frames", tx_seen, 4);

        // R13: set wins over same-cycle clear
        bus_write(1'b0, 8'h50);
        push_tx(8'h77, 0, 0);
        bus_write(1'b1, 8'h77);
        wait_ticks(150);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h50;
        seen = 0;
        repeat (160) begin
            @(negedge clk);
            #1;
            if (bus_rdata[1]) seen = 1;
        end
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        chk("R13 set beats clear", seen, 1'b1);
        wait_ticks(10);

        // R6: 8-bit receive
        send_rx(9'h096, 0, 1);
        bus_read(1'b0, v); chk("R6 rx done", v[0], 1'b1);
        chk("R6 stop copied", v[2], 1'b1);
        bus_read(1'b1, v); chk("R6 data", v, 8'h96);

        // R11: overrun discards
        send_rx(9'h011, 0, 1);
        bus_read(1'b1, v); chk("R11 data kept", v, 8'h96);
        bus_write(1'b0, 8'h50);
        send_rx(9'h042, 0, 0);
        bus_read(1'b0, v); chk("R6 bad stop flag", v[0], 1'b1);
        chk("R6 stop zero copied", v[2], 1'b0);
        bus_read(1'b1, v); chk("R6 data 42", v, 8'h42);
        bus_write(1'b0, 8'h70);

        // R10: filter in 8-bit mode
        send_rx(9'h024, 0, 0);
        bus_read(1'b0, v); chk("R10 dropped flag", v[0], 1'b0);
        bus_read(1'b1, v); chk("R10 dropped data", v, 8'h42);
        send_rx(9'h024, 0, 1);
        bus_read(1'b0, v); chk("R10 accepted flag", v[0], 1'b1);
        bus_read(1'b1, v); chk("R10 accepted data", v, 8'h24);

        // R7: 9-bit receive
        bus_write(1'b0, 8'hD0);
        send_rx(9'h1C3, 1, 1);
        bus_read(1'b0, v); chk("R7 bit9 one", v[2], 1'b1);
        chk("R7 flag", v[0], 1'b1);
        bus_read(1'b1, v); chk("R7 data C3", v, 8'hC3);
        bus_write(1'b0, 8'hD0);
        send_rx(9'h03E, 1, 1);
        bus_read(1'b0, v); chk("R7 bit9 zero", v[2], 1'b0);
        bus_read(1'b1, v); chk("R7 data 3E", v, 8'h3E);

        // R9: filter in 9-bit mode
        bus_write(1'b0, 8'hF0);
        send_rx(9'h055, 1, 1);
        bus_read(1'b0, v); chk("R9 dropped flag", v[0], 1'b0);
        bus_read(1'b1, v); chk("R9 dropped data", v, 8'h3E);
        send_rx(9'h166, 1, 1);
        bus_read(1'b0, v); chk("R9 accepted flag", v[0], 1'b1);
        chk("R9 bit9", v[2], 1'b1);
        bus_read(1'b1, v); chk("R9 accepted data", v, 8'h66);

        // R8: receive disabled
        bus_write(1'b0, 8'h40);
        send_rx(9'h099, 0, 1);
        bus_read(1'b0, v); chk("R8 no flag", v[0], 1'b0);
        bus_read(1'b1, v); chk("R8 data kept", v, 8'h66);

        // R12: short start pulse rejected
        bus_write(1'b0, 8'h50);
        rxd = 1'b0;
        wait_ticks(3);
        rxd = 1'b1;
        wait_ticks(30);
        bus_read(1'b0, v); chk("R12 glitch flag", v[0], 1'b0);
        bus_read(1'b1, v); chk("R12 glitch data", v, 8'h66);
        send_rx(9'h0C0, 0, 1);
        bus_read(1'b1, v); chk("R12 recovery data", v, 8'hC0);

        wait_ticks(20);
        chk("R5 frame count", tx_seen, tx_pushed);
        chk("R5 queue empty", exp_q.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule